// File: doc/BRIEF.md
# Regulator Fault Protection Supervisor

This block sits between the fault comparators of a multiphase regulator and its PWM stage. It takes four digital fault flags: overcurrent, phase current unbalance, way-overcurrent (1.5 times the overcurrent level) and overvoltage. Each flag must stay present for its own qualification time before it counts. A qualified fault latches a shutdown that drives power-good low and tri-states every PWM output. An overvoltage fault is handled in two steps. The block first actively discharges the output. It tri-states the PWM outputs only when a below-target comparator reports that the output has fallen under its target.

All qualification times are given in microseconds. They are converted to clock cycles from the clock rate parameter `CLK_KHZ`. A latched fault is cleared only by reset or by taking the enable input low and then high again. A cause code records the fault that caused the latch, so that a host can read it after the shutdown.

Controller states: DISABLED (enable low or after reset), RUN (regulating, faults armed), OV_DISCHARGE (output being pulled down), LATCHED (PWM outputs tri-stated). The transitions are:
- `start`: DISABLED to RUN when en is high.
- `stop`: any state to DISABLED when en is low.
- `ov_trip`: RUN to OV_DISCHARGE.
- `hard_trip`: RUN to LATCHED on an overcurrent, unbalance or way-overcurrent trip.
- `discharged`: OV_DISCHARGE to LATCHED when below_tgt is high.

Top module: `fault_supervisor`

## Requirements
- R1: After reset the block is in DISABLED. In this state pgood=0, pwm_tristate=1, ov_pulldown=0 and fault_cause=0.
- R2: In DISABLED with en high, the block enters RUN on the next clock edge. In RUN, pgood=1, pwm_tristate=0 and ov_pulldown=0. Entering RUN clears fault_cause to 0.
- R3: In RUN, an oc_flag sampled high on OC_US*CLK_KHZ/1000 consecutive edges moves the block to LATCHED on the last of those edges. In LATCHED, pgood=0 and pwm_tristate=1. fault_cause becomes 1.
- R4: In RUN, an unb_flag sampled high on UNB_US*CLK_KHZ/1000 consecutive edges moves the block to LATCHED on the last of those edges. fault_cause becomes 2.
- R5: If a qualifying flag drops before its time expires, its count restarts from zero, and no trip results from the shorter run.
- R6: In RUN, a woc_flag sampled high on a single edge moves the block to LATCHED on that edge. fault_cause becomes 3.
- R7: In RUN, an ov_flag sampled high on one edge moves the block to OV_DISCHARGE. In OV_DISCHARGE, pgood=0, ov_pulldown=1 and pwm_tristate=0. fault_cause becomes 4.
- R8: In OV_DISCHARGE with en high, the block stays in OV_DISCHARGE until below_tgt is sampled high. It then enters LATCHED, with ov_pulldown=0 and pwm_tristate=1.
- R9: LATCHED holds while en stays high, whatever the fault flags do. A low en moves any state to DISABLED. fault_cause keeps its value through DISABLED and clears only on the next entry to RUN.
- R10: While en is low, all fault flags are ignored. The block stays in DISABLED and fault_cause is unchanged.
- R11: When several trips qualify on the same edge, the cause is chosen by priority: ov (4) first, then woc (3), then oc (1), then unb (2). Only the first latching fault is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_KHZ kHz |
| rst_n | input | 1 | Active-low reset (supply re-power) |
| en | input | 1 | Regulator enable; a low-then-high toggle clears a latch |
| oc_flag | input | 1 | Overcurrent comparator flag |
| unb_flag | input | 1 | Phase current unbalance flag |
| woc_flag | input | 1 | Way-overcurrent flag |
| ov_flag | input | 1 | Overvoltage flag |
| below_tgt | input | 1 | Output voltage is below its target |
| pgood | output | 1 | Power-good |
| pwm_tristate | output | 1 | Command to tri-state all PWM outputs |
| ov_pulldown | output | 1 | Command to actively discharge the output |
| fault_cause | output | 3 | 0 none, 1 oc, 2 unb, 3 woc, 4 ov |

## Verification
The bench goes after the following corner cases:
- **Overcurrent one cycle short.** An oc_flag held one cycle short of its time, then dropped, must not trip. A counter that fails to restart would latch on the next short burst, and an off-by-one counter would latch one cycle early or late.
- **Simultaneous faults.** Overvoltage arriving together with way-overcurrent must take the discharge path. A wrong priority would tri-state at once, without pulling the output down.
- **Flags after a latch or while disabled.** Flags toggling after a latch, or while en is low, must leave both the state and the cause untouched. A design that re-armed would overwrite the recorded cause or restart without the enable toggle.

A long random run compares every cycle against a cycle model written in the bench.

// File: rtl/fps_pkg.sv
package fps_pkg;
    typedef enum logic [1:0] {
        ST_DISABLED     = 2'd0,
        ST_RUN          = 2'd1,
        ST_OV_DISCHARGE = 2'd2,
        ST_LATCHED      = 2'd3
    } fps_state_e;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_OC   = 3'd1,
        CAUSE_UNB  = 3'd2,
        CAUSE_WOC  = 3'd3,
        CAUSE_OV   = 3'd4
    } fps_cause_e;

    localparam int NUM_FAULTS = 4;
    localparam int IDX_OC  = 0;
    localparam int IDX_UNB = 1;
    localparam int IDX_WOC = 2;
    localparam int IDX_OV  = 3;
endpackage

// File: rtl/fps_qual.sv
module fps_qual #(
    parameter int unsigned DELAY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic flag,
    output logic trip
);
    localparam int unsigned CW = (DELAY > 2) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'((DELAY > 0) ? DELAY - 1 : 0);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm || !flag) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign trip = arm && flag && (cnt == LAST);

    generate
        if (DELAY > 1) begin : g_delayed
            // R5: a flag that has just risen cannot trip a delayed qualifier
            p_no_early_trip_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(flag) |-> !trip);
        end
    endgenerate
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
    import fps_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  below_tgt,
    input  logic [NUM_FAULTS-1:0] trips,
    output logic                  arm,
    output logic                  pgood,
    output logic                  pwm_tristate,
    output logic                  ov_pulldown,
    output logic [2:0]            fault_cause
);
    fps_state_e state, state_nx;
    fps_cause_e cause, cause_nx;

    always_comb begin
        state_nx = state;
        cause_nx = cause;
        unique case (state)
            ST_DISABLED: begin
                if (en) begin
                    state_nx = ST_RUN;
                    cause_nx = CAUSE_NONE;
                end
            end
            ST_RUN: begin
                if (!en) begin
                    state_nx = ST_DISABLED;
                end else if (trips[IDX_OV]) begin
                    state_nx = ST_OV_DISCHARGE;
                    cause_nx = CAUSE_OV;
                end else if (trips[IDX_WOC]) begin
                    state_nx = ST_LATCHED;
                    cause_nx = CAUSE_WOC;
                end else if (trips[IDX_OC]) begin
                    state_nx = ST_LATCHED;
                    cause_nx = CAUSE_OC;
                end else if (trips[IDX_UNB]) begin
                    state_nx = ST_LATCHED;
                    cause_nx = CAUSE_UNB;
                end
            end
            ST_OV_DISCHARGE: begin
                if (!en)            state_nx = ST_DISABLED;
                else if (below_tgt) state_nx = ST_LATCHED;
            end
            ST_LATCHED: begin
                if (!en) state_nx = ST_DISABLED;
            end
            default: state_nx = ST_DISABLED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_DISABLED;
            cause <= CAUSE_NONE;
        end else begin
            state <= state_nx;
            cause <= cause_nx;
        end
    end

    always_comb begin
        arm          = 1'b0;
        pgood        = 1'b0;
        pwm_tristate = 1'b1;
        ov_pulldown  = 1'b0;
        unique case (state)
            ST_DISABLED: ;
            ST_RUN: begin
                arm          = en;
                pgood        = 1'b1;
                pwm_tristate = 1'b0;
            end
            ST_OV_DISCHARGE: begin
                pwm_tristate = 1'b0;
                ov_pulldown  = 1'b1;
            end
            ST_LATCHED: ;
            default: ;
        endcase
    end

    assign fault_cause = cause;

    p_woc_immediate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en && trips[IDX_WOC] && !trips[IDX_OV]) |=> (state == ST_LATCHED));
    p_ov_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en && trips[IDX_OV]) |=> (ov_pulldown && fault_cause == CAUSE_OV));
    p_discharge_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OV_DISCHARGE && en && !below_tgt) |=> ov_pulldown);
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LATCHED && en) |=> (pwm_tristate && !pgood && $stable(fault_cause)));
    p_ignore_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISABLED && !en) |=> (state == ST_DISABLED && $stable(fault_cause)));
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fps_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 250000,
    parameter int unsigned OC_US   = 120,
    parameter int unsigned UNB_US  = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       oc_flag,
    input  logic       unb_flag,
    input  logic       woc_flag,
    input  logic       ov_flag,
    input  logic       below_tgt,
    output logic       pgood,
    output logic       pwm_tristate,
    output logic       ov_pulldown,
    output logic [2:0] fault_cause
);
    localparam int unsigned OC_N  = (CLK_KHZ * OC_US) / 1000;
    localparam int unsigned UNB_N = (CLK_KHZ * UNB_US) / 1000;
    localparam int unsigned DLY [NUM_FAULTS] = '{OC_N, UNB_N, 1, 1};

    logic [NUM_FAULTS-1:0] flags;
    logic [NUM_FAULTS-1:0] trips;
    logic                  arm;

    always_comb begin
        flags          = '0;
        flags[IDX_OC]  = oc_flag;
        flags[IDX_UNB] = unb_flag;
        flags[IDX_WOC] = woc_flag;
        flags[IDX_OV]  = ov_flag;
    end

    generate
        for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_qual
            fps_qual #(.DELAY(DLY[i])) u_qual (
                .clk  (clk),
                .rst_n(rst_n),
                .arm  (arm),
                .flag (flags[i]),
                .trip (trips[i])
            );
        end
    endgenerate

    fps_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .below_tgt   (below_tgt),
        .trips       (trips),
        .arm         (arm),
        .pgood       (pgood),
        .pwm_tristate(pwm_tristate),
        .ov_pulldown (ov_pulldown),
        .fault_cause (fault_cause)
    );
endmodule

// File: tb/fault_supervisor_test.sv
`timescale 1ns/1ps
module fault_supervisor_test;
    localparam int unsigned CLK_KHZ = 100;
    localparam int unsigned OC_N  = CLK_KHZ * 120 / 1000;   // 12 cycles
    localparam int unsigned UNB_N = CLK_KHZ * 1000 / 1000;  // 100 cycles

    logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
    logic oc = 1'b0, unb = 1'b0, woc = 1'b0, ov = 1'b0, below = 1'b0;
    logic pgood, pwm_tristate, ov_pulldown;
    logic [2:0] fault_cause;

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    // bench model: 0 disabled, 1 run, 2 ov discharge, 3 latched
    int m_state = 0, m_cause = 0, m_oc = 0, m_unb = 0;

    always #2 clk = ~clk;

    fault_supervisor #(.CLK_KHZ(CLK_KHZ), .OC_US(120), .UNB_US(1000)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .oc_flag(oc), .unb_flag(unb),
        .woc_flag(woc), .ov_flag(ov), .below_tgt(below), .pgood(pgood),
        .pwm_tristate(pwm_tristate), .ov_pulldown(ov_pulldown),
        .fault_cause(fault_cause)
    );

    function automatic logic [2:0] exp_outs(int st);
        // {pgood, pwm_tristate, ov_pulldown}
        case (st)
            1:       return 3'b100;
            2:       return 3'b001;
            default: return 3'b010;
        endcase
    endfunction

    function automatic int next_cnt(bit armed, bit flag, int cnt, int n);
        if (!armed || !flag) return 0;
        return (cnt < n - 1) ? cnt + 1 : cnt;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state <= 0; m_cause <= 0; m_oc <= 0; m_unb <= 0;
        end else begin
            automatic bit armed = (m_state == 1) && en;
            automatic bit oc_t  = armed && oc && (m_oc == OC_N - 1);
            automatic bit unb_t = armed && unb && (m_unb == UNB_N - 1);
            m_oc  <= next_cnt(armed, oc, m_oc, OC_N);
            m_unb <= next_cnt(armed, unb, m_unb, UNB_N);
            case (m_state)
                0: if (en) begin m_state <= 1; m_cause <= 0; end
                1: begin
                    if (!en)        m_state <= 0;
                    else if (ov)    begin m_state <= 2; m_cause <= 4; end
                    else if (woc)   begin m_state <= 3; m_cause <= 3; end
                    else if (oc_t)  begin m_state <= 3; m_cause <= 1; end
                    else if (unb_t) begin m_state <= 3; m_cause <= 2; end
                end
                2: if (!en) m_state <= 0; else if (below) m_state <= 3;
                default: if (!en) m_state <= 0;
            endcase
        end
    end

    // compare away from the active edge, every cycle
    always @(negedge clk) begin
        automatic logic [2:0] e = exp_outs(m_state);
        checks++;
        if ({pgood, pwm_tristate, ov_pulldown} !== e || fault_cause !== m_cause[2:0]) begin
            fails++;
            $display("FAIL %s: got pg/ts/pd=%b cause=%0d expected %b cause=%0d",
                     cur_req, {pgood, pwm_tristate, ov_pulldown}, fault_cause, e, m_cause);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flags();
        oc = 0; unb = 0; woc = 0; ov = 0; below = 0;
    endtask

    task automatic restart();
        en = 0; step(2); en = 1; step(2);
    endtask

    initial begin
        void'($urandom(32'd1234));
        cur_req = "R1"; step(3); rst_n = 1; step(3);
        cur_req = "R2"; en = 1; step(3);
        cur_req = "R5"; oc = 1; step(OC_N - 1); oc = 0; step(2);
        oc = 1; step(OC_N - 1); oc = 0; step(3);
        cur_req = "R3"; oc = 1; step(OC_N + 2); oc = 0;
        cur_req = "R9"; woc = 1; ov = 1; unb = 1; step(5); clear_flags();
        en = 0; step(3);
        cur_req = "R10"; woc = 1; ov = 1; oc = 1; step(20); clear_flags();
        cur_req = "R9"; en = 1; step(3);
        cur_req = "R4"; unb = 1; step(UNB_N - 1); unb = 0; step(1);
        unb = 1; step(UNB_N + 2); unb = 0; restart();
        cur_req = "R6"; woc = 1; step(1); woc = 0; step(3); restart();
        cur_req = "R7"; ov = 1; step(1); ov = 0; step(10);
        cur_req = "R8"; below = 1; step(1); below = 0; step(4); restart();
        cur_req = "R11"; ov = 1; woc = 1; step(1); clear_flags(); step(3); restart();
        oc = 1; step(OC_N - 1); woc = 1; step(1); clear_flags(); step(3); restart();
        cur_req = "RAND";
        for (int i = 0; i < 20000; i++) begin
            oc    = ($urandom % 100) < 60;
            unb   = ($urandom % 100) < 90;
            woc   = ($urandom % 1000) < 3;
            ov    = ($urandom % 1000) < 2;
            below = ($urandom % 100) < 5;
            if (($urandom % 300) == 0) en = ~en;
            step(1);
        end
        clear_flags(); step(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule